// File: doc/BRIEF.md
# Dual-Mode Buffered Serial Transmitter

This block sends characters on a single serial line. The host writes a byte into a holding register. When the shift engine is free, on a baud tick, the byte is copied into a separate shift register. While that character leaves the line, the host can already write the next byte, so characters can follow each other with no gap.

A mode register selects one of two line formats. The asynchronous format has a start bit, 7 or 8 data bits, an optional parity bit, and one or two stop bits. The clocked synchronous format sends eight data bits and drives a shift clock out beside the data. Baud timing comes from an external single-cycle tick; one tick marks one bit period in the asynchronous format and one clock half-period in the synchronous format.

The write port has no back-pressure: every write is accepted in the cycle it is presented. The empty flag is the only pacing signal. A byte written while the flag is clear replaces the byte still waiting to be sent.

Top module: `duo_serial_tx`

## Requirements
- R1: While rst_n is low, and in the cycle after any cycle with standby high, hold_rd is 0xFF, mode_rd is 0x00, hold_empty is 1, txd is 1 and sck is 1; a character in progress is abandoned.
- R2: A write with wr_sel=0 stores wr_data in the holding register and clears hold_empty; a write with wr_sel=1 stores wr_data[7:0] in the mode register; both values read back on hold_rd and mode_rd on the next cycle.
- R3: On a baud tick that finds hold_empty=0 and the shifter idle or on its final bit period, the holding byte moves into the shifter and hold_empty reads 1 on the next cycle, unless a holding write occurs in that same cycle.
- R4: With mode bit 7 = 0, the line carries, least significant bit first and one bit per baud-tick interval: a 0 start bit, the data bits, then stop bits of 1 (one stop bit when mode bit 3 = 0, two when mode bit 3 = 1); txd and sck change only on a cycle with baud_tick high or standby high.
- R5: With mode bit 7 = 0 and mode bit 6 = 1, only holding bits 0 to 6 are sent and bit 7 is dropped; with mode bit 6 = 0, all 8 bits are sent.
- R6: With mode bit 5 = 1, in the asynchronous format, a parity bit follows the data. Mode bit 4 = 0 makes the count of ones over the sent data bits plus parity even; mode bit 4 = 1 makes that count odd.
- R7: With mode bit 7 = 1, exactly 8 data bits are sent with no start, stop or parity bits, and mode bits 6 to 3 are ignored. sck toggles on every baud tick while a character is sent: it falls when each bit is put on txd and rises on the next tick. In the asynchronous format sck stays 1.
- R8: If a byte is waiting when the final bit period of a character ends, the next character's first bit starts on that same tick.
- R9: A second holding write before the pending byte is taken replaces it; only the latest byte is sent.
- R10: With the shifter idle, txd and sck are both 1, and baud ticks with nothing pending leave them there.
- R11: The line format of a character is fixed when it is loaded; a mode write during the character affects only later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Synchronous return of all state to reset values |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 holding register, 1 mode register |
| wr_data | input | DATA_W | Write data |
| hold_rd | output | DATA_W | Holding register contents |
| mode_rd | output | 8 | Mode register contents |
| baud_tick | input | 1 | One-cycle bit-timing pulse |
| txd | output | 1 | Serial data, idles high |
| sck | output | 1 | Synchronous shift clock, idles high |
| hold_empty | output | 1 | Holding register may be written without losing data |

## Verification
On every cycle, the assertions check the following: the idle line level, that the line moves only on ticks, that sck stays quiet in the asynchronous format, that in the synchronous format data changes only while sck is low, and that the flag is set and cleared by loads, writes and standby. Only the bench's scenarios can show the actual bit order and the frame contents. This covers 7- versus 8-bit truncation, parity sense, stop-bit count, back-to-back chaining, overwrite of a pending byte, and a mode change that must not disturb the character already in flight. The bench sweeps all sixteen asynchronous format combinations over many data values and all 256 bytes in the synchronous format.

// File: rtl/duo_tx_pkg.sv
package duo_tx_pkg;
  typedef struct packed {
    logic       sync_mode;
    logic       short_char;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
    logic       mp_flag;
    logic [1:0] clk_src;
  } mode_t;

  localparam logic [7:0] MODE_RESET = 8'h00;
endpackage

// File: rtl/duo_tx_regs.sv
module duo_tx_regs
  import duo_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [DATA_W-1:0] hold_q,
  output mode_t             mode_q,
  output logic              hold_empty
);
  logic wr_hold;
  logic wr_mode;

  assign wr_hold = wr_en && !wr_sel;
  assign wr_mode = wr_en && wr_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '1;
      mode_q     <= mode_t'(MODE_RESET);
      hold_empty <= 1'b1;
    end else if (standby) begin
      hold_q     <= '1;
      mode_q     <= mode_t'(MODE_RESET);
      hold_empty <= 1'b1;
    end else begin
      if (wr_hold) hold_q <= wr_data;
      if (wr_mode) mode_q <= mode_t'(wr_data[7:0]);
      if (wr_hold)   hold_empty <= 1'b0;
      else if (load) hold_empty <= 1'b1;
    end
  end

  AST_HOLD_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hold && !standby) |=> (!hold_empty && hold_q == $past(wr_data))); // R2
  AST_LOAD_SETS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wr_hold && !standby) |=> hold_empty); // R3
  AST_STANDBY_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (hold_q == '1 && mode_q == mode_t'(MODE_RESET) && hold_empty)); // R1
  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_empty && !load && !standby) |=> !hold_empty); // R9
endmodule

// File: rtl/duo_tx_frame.sv
module duo_tx_frame #(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  logic               sync_mode,
  input  logic               short_char,
  input  logic               par_en,
  input  logic               par_odd,
  input  logic               two_stop,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   nbits
);
  int                nd;
  int                total;
  logic              par_bit;
  logic [DATA_W-1:0] sent_mask;

  always_comb begin
    nd        = short_char ? DATA_W - 1 : DATA_W;
    sent_mask = '1;
    if (short_char) sent_mask[DATA_W-1] = 1'b0;
    par_bit   = (^(data & sent_mask)) ^ par_odd;
    frame     = '1;
    if (sync_mode) begin
      frame[DATA_W-1:0] = data;
      total             = DATA_W;
    end else begin
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++)
        if (i < nd) frame[i+1] = data[i];
      for (int j = 1; j < FRAME_W; j++)
        if (par_en && j == nd + 1) frame[j] = par_bit;
      total = 2 + nd + (par_en ? 1 : 0) + (two_stop ? 1 : 0);
    end
    nbits = CNT_W'(total);
  end
endmodule

// File: rtl/duo_tx_shift.sv
module duo_tx_shift #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               standby,
  input  logic               baud_tick,
  input  logic               pending,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   nbits_in,
  input  logic               sync_in,
  output logic               load,
  output logic               txd,
  output logic               sck
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               busy;
  logic               sync_q;
  logic               sck_q;
  logic               last;

  assign last = busy && (cnt == CNT_W'(1)) && (!sync_q || sck_q);
  assign load = baud_tick && pending && (!busy || last);
  assign txd  = shreg[0];
  assign sck  = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1; cnt <= '0; busy <= 1'b0; sync_q <= 1'b0; sck_q <= 1'b1;
    end else if (standby) begin
      shreg <= '1; cnt <= '0; busy <= 1'b0; sync_q <= 1'b0; sck_q <= 1'b1;
    end else if (baud_tick) begin
      if (load) begin
        shreg  <= frame_in;
        cnt    <= nbits_in;
        busy   <= 1'b1;
        sync_q <= sync_in;
        sck_q  <= !sync_in;
      end else if (!busy || last) begin
        shreg <= '1;
        cnt   <= '0;
        busy  <= 1'b0;
        sck_q <= 1'b1;
      end else if (sync_q && !sck_q) begin
        sck_q <= 1'b1;
      end else begin
        shreg <= {1'b1, shreg[FRAME_W-1:1]};
        cnt   <= cnt - 1'b1;
        if (sync_q) sck_q <= 1'b0;
      end
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (txd && sck)); // R10
  AST_ASYNC_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sync_q) |-> sck); // R7
  AST_MOVE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!baud_tick && !standby) |=> ($stable(txd) && $stable(sck))); // R4
  AST_SYNC_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n || standby)
    (busy && sync_q && !$stable(txd)) |-> !sck); // R7
  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0 && cnt <= CNT_W'(FRAME_W))); // R4
endmodule

// File: rtl/duo_serial_tx.sv
module duo_serial_tx
  import duo_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] hold_rd,
  output logic [7:0]        mode_rd,
  input  logic              baud_tick,
  output logic              txd,
  output logic              sck,
  output logic              hold_empty
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [DATA_W-1:0]  hold_q;
  mode_t              mode_q;
  logic               load;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  duo_tx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .load(load),
    .hold_q(hold_q), .mode_q(mode_q), .hold_empty(hold_empty)
  );

  duo_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
    .data(hold_q), .sync_mode(mode_q.sync_mode), .short_char(mode_q.short_char),
    .par_en(mode_q.par_en), .par_odd(mode_q.par_odd), .two_stop(mode_q.two_stop),
    .frame(frame), .nbits(nbits)
  );

  duo_tx_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .standby(standby), .baud_tick(baud_tick),
    .pending(!hold_empty), .frame_in(frame), .nbits_in(nbits),
    .sync_in(mode_q.sync_mode), .load(load), .txd(txd), .sck(sck)
  );

  assign hold_rd = hold_q;
  assign mode_rd = mode_q;

  AST_NO_SILENT_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_empty && !wr_en && !standby) |=> hold_empty); // R3
endmodule

// File: tb/duo_serial_tx_test.sv
`timescale 1ns/1ps
module duo_serial_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       standby = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] hold_rd;
  logic [7:0] mode_rd;
  logic       baud_tick = 1'b0;
  logic       txd;
  logic       sck;
  logic       hold_empty;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  duo_serial_tx #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .hold_rd(hold_rd), .mode_rd(mode_rd), .baud_tick(baud_tick),
    .txd(txd), .sck(sck), .hold_empty(hold_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); baud_tick = 1'b1;
    @(negedge clk); baud_tick = 1'b0;
  endtask

  function automatic int a_len(input logic [7:0] m);
    return 2 + (m[6] ? 7 : 8) + int'(m[5]) + int'(m[3]);
  endfunction

  function automatic logic a_bit(input logic [7:0] m, input logic [7:0] d, input int idx);
    int nd = m[6] ? 7 : 8;
    logic [7:0] sent = m[6] ? (d & 8'h7F) : d;
    if (idx == 0) return 1'b0;
    if (idx <= nd) return d[idx-1];
    if (m[5] && idx == nd + 1) return (^sent) ^ m[4];
    return 1'b1;
  endfunction

  function automatic string a_req(input logic [7:0] m, input int idx);
    int nd = m[6] ? 7 : 8;
    if (m[5] && idx == nd + 1) return "R6 parity";
    if (m[6] && idx >= 1 && idx <= nd) return "R5 short data";
    return "R4 async frame";
  endfunction

  // check async bits from idx_from to the last bit; the first is already on the line
  task automatic async_rest(input logic [7:0] m, input logic [7:0] d, input int idx_from);
    chk(a_req(m, idx_from), int'(txd), int'(a_bit(m, d, idx_from)));
    for (int i = idx_from + 1; i < a_len(m); i++) begin
      tick();
      chk(a_req(m, i), int'(txd), int'(a_bit(m, d, i)));
      chk("R7 async sck high", int'(sck), 1);
    end
  endtask

  task automatic sync_rest(input logic [7:0] d, input int t_from);
    for (int t = t_from; t <= 16; t++) begin
      if (t != t_from) tick();
      chk("R7 sync sck", int'(sck), (t % 2 == 1) ? 0 : 1);
      chk("R7 sync data", int'(txd), int'(d[(t-1)/2]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset hold", int'(hold_rd), 8'hFF);
    chk("R1 reset mode", int'(mode_rd), 8'h00);
    chk("R1 reset empty", int'(hold_empty), 1);
    chk("R1 reset txd", int'(txd), 1);
    chk("R1 reset sck", int'(sck), 1);
    rst_n = 1'b1;
    @(negedge clk);
    tick(); tick();
    chk("R10 idle txd", int'(txd), 1);
    chk("R10 idle sck", int'(sck), 1);

    // asynchronous sweep over all 16 format combinations
    for (int m4 = 0; m4 < 16; m4++) begin
      logic [7:0] m = 8'(m4 << 3);
      wr(1'b1, m);
      chk("R2 mode readback", int'(mode_rd), int'(m));
      for (int k = 0; k < 64; k++) begin
        logic [7:0] d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'((k * 53 + m4 * 7) & 8'hFF);
        wr(1'b0, d);
        chk("R2 hold readback", int'(hold_rd), int'(d));
        chk("R2 empty cleared", int'(hold_empty), 0);
        tick();
        chk("R3 empty set on load", int'(hold_empty), 1);
        async_rest(m, d, 0);
        tick();
        chk("R10 idle after char", int'(txd), 1);
      end
    end

    // synchronous sweep; bits 6..3 vary and must be ignored
    for (int d = 0; d < 256; d++) begin
      logic [7:0] m = (d % 3 == 0) ? 8'h80 : (d % 3 == 1) ? 8'hC0 : 8'hF8;
      wr(1'b1, m);
      wr(1'b0, 8'(d));
      tick();
      sync_rest(8'(d), 1);
      tick();
      chk("R7 sync idle sck", int'(sck), 1);
      chk("R7 sync idle txd", int'(txd), 1);
    end

    // R8 async back-to-back
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h3C);
    tick();
    wr(1'b0, 8'hC3);
    chk("R8 second byte pending", int'(hold_empty), 0);
    for (int i = 1; i < 10; i++) begin
      tick();
      chk("R8 first char", int'(txd), int'(a_bit(8'h00, 8'h3C, i)));
    end
    tick();
    chk("R8 next start bit", int'(txd), 0);
    chk("R8 empty at chain", int'(hold_empty), 1);
    async_rest(8'h00, 8'hC3, 0);
    tick();
    chk("R8 idle after chain", int'(txd), 1);

    // R8 sync back-to-back
    wr(1'b1, 8'h80);
    wr(1'b0, 8'hA1);
    tick();
    wr(1'b0, 8'h4E);
    sync_rest(8'hA1, 1);
    tick();
    chk("R8 sync chain empty", int'(hold_empty), 1);
    sync_rest(8'h4E, 1);
    tick();
    chk("R8 sync chain idle", int'(sck), 1);

    // R9 overwrite of a pending byte
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h11);
    wr(1'b0, 8'hE7);
    chk("R9 hold overwritten", int'(hold_rd), 8'hE7);
    tick();
    async_rest(8'h00, 8'hE7, 0);
    tick();
    chk("R9 single char only", int'(txd), 1);

    // R11 mode write during a character
    wr(1'b0, 8'h0F);
    tick(); tick(); tick();
    wr(1'b1, 8'h38);
    chk("R11 mode updated", int'(mode_rd), 8'h38);
    async_rest(8'h00, 8'h0F, 2);
    tick();
    chk("R11 length kept", int'(txd), 1);

    // R1 standby in the middle of a synchronous character
    wr(1'b1, 8'h80);
    wr(1'b0, 8'h5A);
    tick();
    wr(1'b0, 8'h77);
    tick(); tick();
    chk("R1 sck low before standby", int'(sck), 0);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    chk("R1 standby hold", int'(hold_rd), 8'hFF);
    chk("R1 standby mode", int'(mode_rd), 8'h00);
    chk("R1 standby empty", int'(hold_empty), 1);
    chk("R1 standby sck", int'(sck), 1);
    chk("R1 standby txd", int'(txd), 1);
    tick();
    chk("R1 nothing resumes", int'(txd), 1);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule